// File: doc/BRIEF.md
# System Performance Monitor Control Register

This block is the control register of one system-level performance monitoring unit, together with the small bank of event counters that it governs. Software reaches the register through a simple write/read port that carries a unit index. The unit answers only to its own index. The register holds a global count enable and a write-one counter-clear strobe. It also holds optional control bits for trace, halt-on-debug, freeze-on-overflow, export and a read-only "not accessible" indication. Each optional bit exists only when the matching capability input bit is set.

Each counter advances on its own event input while the unit is enabled and not frozen. When a counter wraps from all-ones to zero, it sets a sticky overflow flag. A flag clears when 1 is written to the matching flag-clear input. The overflow interrupt is the OR of the flags, gated by the enable bit. Clearing the counters never touches the flags.

Top module: `spmu_ctrl_top`

## Requirements
- R1: Register bit 0 is the count enable; while it is 0 no counter changes except by a counter clear.
- R2: Writing 1 to bit 1 sets all counters to zero on that write's clock edge. Writing 0 to bit 1 leaves the counters unchanged, and bit 1 always reads 0.
- R3: A counter clear leaves every overflow flag unchanged.
- R4: `ovf_irq` is registered and equals (enable AND any overflow flag) as seen one clock earlier, so it is never high unless the enable was 1.
- R5: Bits 63:12, 7:5 and 3:2 read as 0 and ignore writes. `reg_rdata` is registered and reflects the register one clock after `reg_sel` is presented.
- R6: `cap_mask` bit 0 gates bit 4 (export), bit 2 gates bit 9 (freeze), bit 3 gates bit 10 (halt-on-debug) and bit 4 gates bit 11 (trace). A write to such a bit is ignored while its capability bit is 0, and the bit reads 0 while its capability bit is 0.
- R7: Bit 8 is read-only. It reads `unit_blocked` when `cap_mask` bit 1 is set and reads 0 otherwise; writes never change it.
- R8: When `reg_sel` differs from the unit index parameter, reads return 0 and writes are ignored.
- R9: A counter increments by one on each clock edge where its event input is 1 while the unit is enabled and not frozen. A wrap from all-ones to zero sets that counter's sticky flag in `ovf_flags`.
- R10: A 1 on bit i of `ovf_clr` clears overflow flag i on that clock edge.
- R11: While the effective freeze bit is 1 and any overflow flag is set, all counters hold their values. Counting resumes once the flags are cleared.
- R12: After reset, the register, all counters, all flags, `ovf_irq` and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | SEL_W | Unit index for the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| cap_mask | input | 5 | Capability bits for the optional fields |
| unit_blocked | input | 1 | Value shown by the read-only bit 8 |
| evt_inc | input | NUM_CNT | Per-counter event increment |
| ovf_clr | input | NUM_CNT | Per-flag clear, write one to clear |
| cnt_val | output | NUM_CNT*CNT_W | Counter values, counter 0 in the low bits |
| ovf_flags | output | NUM_CNT | Sticky overflow flags |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
A stored control bit that is wrong shows on `reg_rdata` one clock after the unit is selected. A hidden enable or freeze fault shows on `cnt_val` at the first event edge, because the count either moves when it should hold or holds when it should move. A lost or spurious overflow flag shows on `ovf_flags` at the wrap edge and on `ovf_irq` one clock later. A counter clear that disturbs the flags shows at once on `ovf_flags`.

// File: rtl/spmu_pkg.sv
package spmu_pkg;
  localparam int REG_W = 64;
  localparam int CAP_W = 5;

  // register bit positions (software-visible layout)
  localparam int B_EN   = 0;
  localparam int B_CLR  = 1;
  localparam int B_EXP  = 4;
  localparam int B_BLK  = 8;
  localparam int B_FRZ  = 9;
  localparam int B_HDBG = 10;
  localparam int B_TRC  = 11;

  // capability vector positions
  localparam int C_EXP  = 0;
  localparam int C_BLK  = 1;
  localparam int C_FRZ  = 2;
  localparam int C_HDBG = 3;
  localparam int C_TRC  = 4;

  typedef struct packed {
    logic trc;
    logic hdbg;
    logic frz;
    logic exp_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spmu_ctrl_reg.sv
module spmu_ctrl_reg
  import spmu_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int UNIT_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [CAP_W-1:0] cap_mask,
  input  logic             unit_blocked,
  output ctrl_t            ctrl_eff,
  output logic             cnt_clr,
  output logic [REG_W-1:0] reg_rdata
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(UNIT_ID);

  logic  hit;
  logic  wr_hit;
  ctrl_t st_q;

  assign hit    = (reg_sel == MY_SEL);
  assign wr_hit = reg_wr & hit;

  // optional bits keep their old value when their capability is absent
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (wr_hit) begin
      st_q.en <= reg_wdata[B_EN];
      if (cap_mask[C_EXP])  st_q.exp_en <= reg_wdata[B_EXP];
      if (cap_mask[C_FRZ])  st_q.frz    <= reg_wdata[B_FRZ];
      if (cap_mask[C_HDBG]) st_q.hdbg   <= reg_wdata[B_HDBG];
      if (cap_mask[C_TRC])  st_q.trc    <= reg_wdata[B_TRC];
    end
  end

  assign ctrl_eff = st_q & {cap_mask[C_TRC], cap_mask[C_HDBG],
                            cap_mask[C_FRZ], cap_mask[C_EXP], 1'b1};
  assign cnt_clr  = wr_hit & reg_wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (hit) begin
        reg_rdata[B_EN]   <= ctrl_eff.en;
        reg_rdata[B_EXP]  <= ctrl_eff.exp_en;
        reg_rdata[B_BLK]  <= cap_mask[C_BLK] & unit_blocked;
        reg_rdata[B_FRZ]  <= ctrl_eff.frz;
        reg_rdata[B_HDBG] <= ctrl_eff.hdbg;
        reg_rdata[B_TRC]  <= ctrl_eff.trc;
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[REG_W-1:12], reg_wdata[8:5], reg_wdata[3:2]};
endmodule

// File: rtl/spmu_counter_bank.sv
module spmu_counter_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     count_en,
  input  logic                     freeze_en,
  input  logic                     cnt_clr,
  input  logic [NUM_CNT-1:0]       evt_inc,
  input  logic [NUM_CNT-1:0]       ovf_clr,
  output logic [NUM_CNT*CNT_W-1:0] cnt_val,
  output logic [NUM_CNT-1:0]       ovf_flags
);
  logic frozen;
  assign frozen = freeze_en & (|ovf_flags);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    logic             f_q;
    logic             step;
    logic             wrap;

    assign step = evt_inc[i] & count_en & ~frozen;
    assign wrap = step & ~cnt_clr & (c_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
      if (rst || cnt_clr) c_q <= '0;
      else if (step)      c_q <= c_q + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)             f_q <= 1'b0;
      else if (wrap)       f_q <= 1'b1;
      else if (ovf_clr[i]) f_q <= 1'b0;
    end

    assign cnt_val[i*CNT_W +: CNT_W] = c_q;
    assign ovf_flags[i]              = f_q;
  end
endmodule

// File: rtl/spmu_ctrl_top.sv
module spmu_ctrl_top
  import spmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4,
  parameter int UNIT_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEL_W-1:0]         reg_sel,
  input  logic                     reg_wr,
  input  logic [63:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  input  logic [4:0]               cap_mask,
  input  logic                     unit_blocked,
  input  logic [NUM_CNT-1:0]       evt_inc,
  input  logic [NUM_CNT-1:0]       ovf_clr,
  output logic [NUM_CNT*CNT_W-1:0] cnt_val,
  output logic [NUM_CNT-1:0]       ovf_flags,
  output logic                     ovf_irq
);
  ctrl_t ctrl_eff;
  logic  cnt_clr;

  spmu_ctrl_reg #(.SEL_W(SEL_W), .UNIT_ID(UNIT_ID)) u_reg (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .cap_mask(cap_mask), .unit_blocked(unit_blocked),
    .ctrl_eff(ctrl_eff), .cnt_clr(cnt_clr), .reg_rdata(reg_rdata)
  );

  spmu_counter_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .count_en(ctrl_eff.en), .freeze_en(ctrl_eff.frz),
    .cnt_clr(cnt_clr), .evt_inc(evt_inc), .ovf_clr(ovf_clr),
    .cnt_val(cnt_val), .ovf_flags(ovf_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_irq <= 1'b0;
    else     ovf_irq <= ctrl_eff.en & (|ovf_flags);
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_eff.trc, ctrl_eff.hdbg, ctrl_eff.exp_en};
endmodule

// File: rtl/spmu_ctrl_chk.sv
module spmu_ctrl_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4,
  parameter int UNIT_ID = 0
) (
  input logic                     clk,
  input logic                     rst,
  input logic [SEL_W-1:0]         reg_sel,
  input logic [63:0]              reg_rdata,
  input logic [4:0]               cap_mask,
  input logic [NUM_CNT-1:0]       ovf_clr,
  input logic [NUM_CNT*CNT_W-1:0] cnt_val,
  input logic [NUM_CNT-1:0]       ovf_flags,
  input logic                     ovf_irq,
  input logic                     ctrl_en,
  input logic                     ctrl_frz,
  input logic                     cnt_clr
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(UNIT_ID);

  assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !cnt_clr) |=> $stable(cnt_val));

  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt_val == '0));

  assert_clear_keeps_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr && ovf_clr == '0) |=> (ovf_flags == $past(ovf_flags)));

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(ctrl_en));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[63:12] == '0) && (reg_rdata[7:5] == '0) && (reg_rdata[3:1] == '0));

  assert_trace_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_mask[4]) |-> !reg_rdata[11]);

  assert_freeze_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_mask[2]) |-> !reg_rdata[9]);

  assert_blocked_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_mask[1]) |-> !reg_rdata[8]);

  assert_unselected_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel) != MY_SEL) |-> (reg_rdata == '0));

  assert_freeze_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_frz && (|ovf_flags) && !cnt_clr) |=> $stable(cnt_val));
endmodule

bind spmu_ctrl_top spmu_ctrl_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W), .UNIT_ID(UNIT_ID)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .cap_mask(cap_mask), .ovf_clr(ovf_clr), .cnt_val(cnt_val),
  .ovf_flags(ovf_flags), .ovf_irq(ovf_irq), .ctrl_en(ctrl_eff.en),
  .ctrl_frz(ctrl_eff.frz), .cnt_clr(cnt_clr)
);

// File: tb/spmu_ctrl_top_tb.sv
`timescale 1ns/1ps
module spmu_ctrl_top_tb;
  localparam int NUM_CNT = 4;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 4;
  localparam int UNIT_ID = 3;
  localparam logic [SEL_W-1:0] OWN   = SEL_W'(UNIT_ID);
  localparam logic [SEL_W-1:0] OTHER = SEL_W'(5);

  // {wr, cap[4:0], wdata[11:0], expected rdata[11:0]}
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 5'h1F, 12'hFFF, 12'hE11},
    {1'b1, 5'h00, 12'h000, 12'h000},
    {1'b0, 5'h1F, 12'h000, 12'hE10},
    {1'b1, 5'h04, 12'h001, 12'h001},
    {1'b0, 5'h1F, 12'h000, 12'hC11},
    {1'b1, 5'h1F, 12'h002, 12'h000},
    {1'b1, 5'h1B, 12'h210, 12'h010},
    {1'b0, 5'h1F, 12'h000, 12'h010},
    {1'b1, 5'h1F, 12'h000, 12'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SEL_W-1:0] reg_sel = OWN;
  logic reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [4:0] cap_mask = 5'h1F;
  logic unit_blocked = 1'b0;
  logic [NUM_CNT-1:0] evt_inc = '0;
  logic [NUM_CNT-1:0] ovf_clr = '0;
  logic [NUM_CNT*CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0] ovf_flags;
  logic ovf_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] rd;

  always #2.5 clk = ~clk;

  spmu_ctrl_top #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W), .UNIT_ID(UNIT_ID)) u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_mask(cap_mask), .unit_blocked(unit_blocked),
    .evt_inc(evt_inc), .ovf_clr(ovf_clr), .cnt_val(cnt_val),
    .ovf_flags(ovf_flags), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [SEL_W-1:0] s, input logic [63:0] d);
    @(negedge clk); reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [SEL_W-1:0] s, output logic [63:0] d);
    @(negedge clk); reg_sel = s;
    @(posedge clk);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse(input logic [NUM_CNT-1:0] m, input int n);
    @(negedge clk); evt_inc = m;
    repeat (n) @(posedge clk);
    @(negedge clk); evt_inc = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12: reset state
    chk("R12 rdata", reg_rdata, 64'h0);
    chk("R12 counters", 64'(cnt_val), 64'h0);
    chk("R12 flags", 64'(ovf_flags), 64'h0);
    chk("R12 irq", 64'(ovf_irq), 64'h0);

    // R6 R2: vector table of capability gating
    for (int i = 0; i < NV; i++) begin
      cap_mask = VEC[i][28:24];
      if (VEC[i][29]) wr_reg(OWN, {52'h0, VEC[i][23:12]});
      rd_reg(OWN, rd);
      chk("R6 table", rd, {52'h0, VEC[i][11:0]});
    end

    // R5: reserved bits
    cap_mask = 5'h1F;
    wr_reg(OWN, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(OWN, rd);
    chk("R5 reserved", rd, 64'h0000_0000_0000_0E11);

    // R8: other unit index
    wr_reg(OWN, 64'h010);
    wr_reg(OTHER, 64'h201);
    rd_reg(OTHER, rd);
    chk("R8 read other", rd, 64'h0);
    rd_reg(OWN, rd);
    chk("R8 write ignored", rd, 64'h010);

    // R7: read-only bit 8
    unit_blocked = 1'b1;
    rd_reg(OWN, rd);
    chk("R7 shows blocked", rd, 64'h110);
    wr_reg(OWN, 64'h000);
    rd_reg(OWN, rd);
    chk("R7 write ignored", rd, 64'h100);
    cap_mask = 5'h1D;
    rd_reg(OWN, rd);
    chk("R7 gated", rd, 64'h000);
    cap_mask = 5'h1F;
    unit_blocked = 1'b0;

    // R9: counting when enabled
    wr_reg(OWN, 64'h001);
    pulse(4'b0001, 5);
    pulse(4'b0100, 3);
    pulse(4'b0101, 1);
    chk("R9 counts", 64'(cnt_val), 64'h0004_0006);
    // R1: disabled holds
    wr_reg(OWN, 64'h000);
    pulse(4'b1111, 2);
    chk("R1 hold disabled", 64'(cnt_val), 64'h0004_0006);
    // R2: writing 0 to bit 1 changes nothing
    chk("R2 write zero", 64'(cnt_val), 64'h0004_0006);

    // R9: wrap sets flag
    wr_reg(OWN, 64'h001);
    pulse(4'b0010, 256);
    chk("R9 wrap value", 64'(cnt_val), 64'h0004_0006);
    chk("R9 wrap flag", 64'(ovf_flags), 64'h2);
    tick(1);
    chk("R4 irq on", 64'(ovf_irq), 64'h1);
    wr_reg(OWN, 64'h000);
    tick(1);
    chk("R4 irq off when disabled", 64'(ovf_irq), 64'h0);
    chk("R4 flag sticky", 64'(ovf_flags), 64'h2);

    // R3 R2: counter clear keeps flags
    wr_reg(OWN, 64'h002);
    chk("R2 clear", 64'(cnt_val), 64'h0);
    chk("R3 flags kept", 64'(ovf_flags), 64'h2);

    // R11: freeze
    wr_reg(OWN, 64'h201);
    pulse(4'b0001, 3);
    chk("R11 frozen", 64'(cnt_val), 64'h0);
    chk("R4 irq enabled", 64'(ovf_irq), 64'h1);
    // R10: flag clear
    @(negedge clk); ovf_clr = 4'b0010;
    @(posedge clk);
    @(negedge clk); ovf_clr = '0;
    chk("R10 flag cleared", 64'(ovf_flags), 64'h0);
    tick(1);
    chk("R10 irq drops", 64'(ovf_irq), 64'h0);
    pulse(4'b0001, 3);
    chk("R11 resumes", 64'(cnt_val), 64'h3);

    // R12: reset again
    @(negedge clk); rst = 1'b1;
    tick(2);
    rst = 1'b0;
    chk("R12 counters again", 64'(cnt_val), 64'h0);
    rd_reg(OWN, rd);
    chk("R12 register again", rd, 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule